// File: doc/BRIEF.md
# Integer Instruction Decode and Execute Stage

This block takes one 32-bit instruction word from a compact load-store integer subset and, with no clock, produces everything a single-cycle datapath needs to retire it. It splits the two source register specifiers out of the word and sends them to an external register file. It receives the two operand values back and returns the destination index, a write enable, the computed value and, for memory operations, the byte address.

Three encodings are recognised. The register form carries opcode, two sources, a destination, a shift amount and a function code. The immediate form carries opcode, two register fields and a 16-bit constant. The jump form is only identified here. Each instruction has its own rules for which field names the destination and for how the 16-bit constant is widened. Branches and jumps are flagged so that surrounding logic can handle them. Any encoding outside the supported set is reported as illegal and never writes.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode 0 and shamt 0, funct 32 (add), 34 (sub), 36 (and) and 37 (or) write rs_val op rt_val, with modulo 2^32 wrap, to the register named by bits 15:11.
- R2: With opcode 0, funct 42 (slt) and opcode 10 (slti) compare the operands as signed two's-complement values and give exactly 1 when the first is smaller, otherwise 0.
- R3: Opcode 8 (addi) writes rs_val plus the sign-extended bits 15:0 to the register named by bits 20:16.
- R4: Opcodes 12 (andi) and 13 (ori) zero-extend bits 15:0 before the AND or OR with rs_val, and write to the register named by bits 20:16.
- R5: Opcode 15 (lui) writes bits 15:0 into result bits 31:16 with zeros below, independent of rs_val, to the register named by bits 20:16.
- R6: Opcode 35 (load) asserts the load flag, sets the address to rs_val plus the sign-extended bits 15:0, puts the same value on the result, and enables a write to the register named by bits 20:16.
- R7: Opcode 43 (store) asserts the store flag and drives the same address as a load, and never enables a register write.
- R8: The write enable is low whenever the selected destination index is 0.
- R9: The two source indices are always instruction bits 25:21 and 20:16, for every encoding.
- R10: Opcodes 2, 3, 4 and 5, and opcode 0 with funct 8 and shamt 0, raise the control-flow flag, are not illegal, and write nothing.
- R11: Every other encoding, including opcode 0 with a nonzero shamt, raises the illegal flag and keeps the write enable, load and store flags low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| rs_idx_o | output | 5 | First source register index |
| rt_idx_o | output | 5 | Second source register index |
| rs_val_i | input | 32 | Value read for rs_idx_o |
| rt_val_i | input | 32 | Value read for rt_idx_o |
| rd_idx_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Register write enable |
| result_o | output | 32 | Computed result value |
| mem_addr_o | output | 32 | Byte address for a load or store, zero otherwise |
| is_load_o | output | 1 | Instruction is a word load |
| is_store_o | output | 1 | Instruction is a word store |
| is_ctrl_o | output | 1 | Instruction is a branch or jump |
| illegal_o | output | 1 | Encoding is not supported |

## Verification
Register-form arithmetic is driven with mixed-sign operands, so that a swapped subtraction or a wrong logic function gives a different value. The comparison forms are tried with the most negative word and with a negative constant, which separates a signed compare from an unsigned one. The logic-immediate and add-immediate forms use constants with bit 15 set, which shows whether a constant was sign- or zero-extended, and lui is given a nonzero rs value that must not leak into the result. Destination zero, every control-flow opcode, unknown opcodes, unknown function codes and a nonzero shift field check that the write enable stays low where it must.

// File: rtl/ixu_pkg.sv
package ixu_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned RIDX_W   = 5;
  localparam int unsigned OP_W     = 6;
  localparam int unsigned FUNCT_W  = 6;
  localparam int unsigned SHAMT_W  = 5;
  localparam int unsigned IMM_W    = 16;

  localparam int unsigned FUNCT_LSB = 0;
  localparam int unsigned SHAMT_LSB = FUNCT_LSB + FUNCT_W;
  localparam int unsigned RD_LSB    = SHAMT_LSB + SHAMT_W;
  localparam int unsigned RT_LSB    = RD_LSB + RIDX_W;
  localparam int unsigned RS_LSB    = RT_LSB + RIDX_W;
  localparam int unsigned OP_LSB    = RS_LSB + RIDX_W;
  localparam int unsigned IMM_LSB   = 0;

  localparam logic [OP_W-1:0] OPC_REG   = 6'd0;
  localparam logic [OP_W-1:0] OPC_J     = 6'd2;
  localparam logic [OP_W-1:0] OPC_JAL   = 6'd3;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'd4;
  localparam logic [OP_W-1:0] OPC_BNE   = 6'd5;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [OP_W-1:0] OPC_SLTI  = 6'd10;
  localparam logic [OP_W-1:0] OPC_ANDI  = 6'd12;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OP_W-1:0] OPC_LUI   = 6'd15;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'd35;
  localparam logic [OP_W-1:0] OPC_STORE = 6'd43;

  localparam logic [FUNCT_W-1:0] FN_JR  = 6'd8;
  localparam logic [FUNCT_W-1:0] FN_ADD = 6'd32;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'd34;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'd36;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'd37;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_SLT  = 3'd4,
    ALU_PASS = 3'd5
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_SEXT  = 2'd0,
    IMM_ZEXT  = 2'd1,
    IMM_UPPER = 2'd2
  } imm_kind_e;

  typedef struct packed {
    alu_op_e   alu_op;
    imm_kind_e imm_kind;
    logic      use_imm;
    logic      dest_rd;
    logic      wr;
    logic      ld;
    logic      st;
    logic      cf;
    logic      ill;
  } ctrl_t;
endpackage

// File: rtl/ixu_decode.sv
module ixu_decode
  import ixu_pkg::*;
(
  input  logic [OP_W-1:0]    op_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output ctrl_t              ctrl_o
);
  logic shamt_zero;
  assign shamt_zero = (shamt_i == '0);

  always_comb begin
    ctrl_o          = '0;
    ctrl_o.alu_op   = ALU_ADD;
    ctrl_o.imm_kind = IMM_SEXT;
    case (op_i)
      OPC_REG: begin
        ctrl_o.dest_rd = 1'b1;
        if (!shamt_zero) begin
          ctrl_o.ill = 1'b1;
        end else begin
          case (funct_i)
            FN_ADD: begin ctrl_o.alu_op = ALU_ADD; ctrl_o.wr = 1'b1; end
            FN_SUB: begin ctrl_o.alu_op = ALU_SUB; ctrl_o.wr = 1'b1; end
            FN_AND: begin ctrl_o.alu_op = ALU_AND; ctrl_o.wr = 1'b1; end
            FN_OR:  begin ctrl_o.alu_op = ALU_OR;  ctrl_o.wr = 1'b1; end
            FN_SLT: begin ctrl_o.alu_op = ALU_SLT; ctrl_o.wr = 1'b1; end
            FN_JR:  ctrl_o.cf = 1'b1;
            default: ctrl_o.ill = 1'b1;
          endcase
        end
      end
      OPC_ADDI: begin
        ctrl_o.alu_op = ALU_ADD; ctrl_o.use_imm = 1'b1; ctrl_o.wr = 1'b1;
      end
      OPC_SLTI: begin
        ctrl_o.alu_op = ALU_SLT; ctrl_o.use_imm = 1'b1; ctrl_o.wr = 1'b1;
      end
      OPC_ANDI: begin
        ctrl_o.alu_op = ALU_AND; ctrl_o.use_imm = 1'b1; ctrl_o.wr = 1'b1;
        ctrl_o.imm_kind = IMM_ZEXT;
      end
      OPC_ORI: begin
        ctrl_o.alu_op = ALU_OR; ctrl_o.use_imm = 1'b1; ctrl_o.wr = 1'b1;
        ctrl_o.imm_kind = IMM_ZEXT;
      end
      OPC_LUI: begin
        ctrl_o.alu_op = ALU_PASS; ctrl_o.use_imm = 1'b1; ctrl_o.wr = 1'b1;
        ctrl_o.imm_kind = IMM_UPPER;
      end
      OPC_LOAD: begin
        ctrl_o.use_imm = 1'b1; ctrl_o.wr = 1'b1; ctrl_o.ld = 1'b1;
      end
      OPC_STORE: begin
        ctrl_o.use_imm = 1'b1; ctrl_o.st = 1'b1;
      end
      OPC_J, OPC_JAL, OPC_BEQ, OPC_BNE: ctrl_o.cf = 1'b1;
      default: ctrl_o.ill = 1'b1;
    endcase
  end
endmodule

// File: rtl/ixu_imm_ext.sv
module ixu_imm_ext
  import ixu_pkg::*;
(
  input  logic [IMM_W-1:0] imm_i,
  input  imm_kind_e        kind_i,
  output logic [XLEN-1:0]  imm_o
);
  localparam int unsigned PAD_W = XLEN - IMM_W;

  always_comb begin
    case (kind_i)
      IMM_ZEXT:  imm_o = {{PAD_W{1'b0}}, imm_i};
      IMM_UPPER: imm_o = {imm_i, {PAD_W{1'b0}}};
      default:   imm_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
    endcase
  end
endmodule

// File: rtl/ixu_alu.sv
module ixu_alu
  import ixu_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] diff;
  logic            lt;

  assign diff = a_i - b_i;
  // signed less-than from sign bits and the difference
  assign lt = (a_i[XLEN-1] != b_i[XLEN-1]) ? a_i[XLEN-1] : diff[XLEN-1];

  always_comb begin
    case (op_i)
      ALU_ADD:  res_o = a_i + b_i;
      ALU_SUB:  res_o = diff;
      ALU_AND:  res_o = a_i & b_i;
      ALU_OR:   res_o = a_i | b_i;
      ALU_SLT:  res_o = {{(XLEN-1){1'b0}}, lt};
      default:  res_o = b_i;
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import ixu_pkg::*;
(
  input  logic [XLEN-1:0]   instr_i,
  output logic [RIDX_W-1:0] rs_idx_o,
  output logic [RIDX_W-1:0] rt_idx_o,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  output logic [RIDX_W-1:0] rd_idx_o,
  output logic              wr_en_o,
  output logic [XLEN-1:0]   result_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic              is_load_o,
  output logic              is_store_o,
  output logic              is_ctrl_o,
  output logic              illegal_o
);
  ctrl_t             ctrl;
  logic [RIDX_W-1:0] rd_field;
  logic [RIDX_W-1:0] dest;
  logic [XLEN-1:0]   imm_ext;
  logic [XLEN-1:0]   opnd_b;
  logic [XLEN-1:0]   alu_res;

  assign rs_idx_o = instr_i[RS_LSB +: RIDX_W];
  assign rt_idx_o = instr_i[RT_LSB +: RIDX_W];
  assign rd_field = instr_i[RD_LSB +: RIDX_W];

  ixu_decode u_decode (
    .op_i    (instr_i[OP_LSB +: OP_W]),
    .shamt_i (instr_i[SHAMT_LSB +: SHAMT_W]),
    .funct_i (instr_i[FUNCT_LSB +: FUNCT_W]),
    .ctrl_o  (ctrl)
  );

  ixu_imm_ext u_imm (
    .imm_i  (instr_i[IMM_LSB +: IMM_W]),
    .kind_i (ctrl.imm_kind),
    .imm_o  (imm_ext)
  );

  assign opnd_b = ctrl.use_imm ? imm_ext : rt_val_i;

  ixu_alu u_alu (
    .a_i   (rs_val_i),
    .b_i   (opnd_b),
    .op_i  (ctrl.alu_op),
    .res_o (alu_res)
  );

  assign dest       = ctrl.dest_rd ? rd_field : rt_idx_o;
  assign rd_idx_o   = dest;
  assign wr_en_o    = ctrl.wr && (dest != '0);
  assign result_o   = alu_res;
  assign mem_addr_o = (ctrl.ld || ctrl.st) ? alu_res : '0;
  assign is_load_o  = ctrl.ld;
  assign is_store_o = ctrl.st;
  assign is_ctrl_o  = ctrl.cf;
  assign illegal_o  = ctrl.ill;
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk
  import ixu_pkg::*;
(
  input logic [XLEN-1:0]   instr_i,
  input logic [RIDX_W-1:0] rd_idx_o,
  input logic              wr_en_o,
  input logic [XLEN-1:0]   result_o,
  input logic              is_load_o,
  input logic              is_store_o,
  input logic              is_ctrl_o,
  input logic              illegal_o
);
  logic [OP_W-1:0]    op;
  logic [FUNCT_W-1:0] fn;
  assign op = instr_i[OP_LSB +: OP_W];
  assign fn = instr_i[FUNCT_LSB +: FUNCT_W];

  always_comb begin
    a_r11_illegal_quiet: assert (!illegal_o || (!wr_en_o && !is_load_o && !is_store_o))
      else $error("illegal encoding produced side effects");
    a_r8_zero_dest: assert (!wr_en_o || (rd_idx_o != '0))
      else $error("write enabled to index 0");
    a_r10_ctrl_no_write: assert (!is_ctrl_o || (!wr_en_o && !illegal_o))
      else $error("control-flow op writes or is illegal");
    a_r2_slt_bool: assert (!(op == OPC_SLTI || (op == OPC_REG && fn == FN_SLT && !illegal_o))
                           || (result_o[XLEN-1:1] == '0))
      else $error("compare result not 0 or 1");
    a_r5_lui_low_zero: assert (op != OPC_LUI || result_o[IMM_W-1:0] == '0)
      else $error("lui low half not zero");
    a_r7_kind_excl: assert ($onehot0({is_load_o, is_store_o, is_ctrl_o, illegal_o}))
      else $error("class flags overlap");
  end
endmodule

bind int_exec_unit int_exec_unit_chk u_chk (
  .instr_i    (instr_i),
  .rd_idx_o   (rd_idx_o),
  .wr_en_o    (wr_en_o),
  .result_o   (result_o),
  .is_load_o  (is_load_o),
  .is_store_o (is_store_o),
  .is_ctrl_o  (is_ctrl_o),
  .illegal_o  (illegal_o)
);

// File: tb/test_int_exec_unit.sv
`timescale 1ns/1ps
module test_int_exec_unit;
  logic        clk = 1'b0;
  logic [31:0] instr = '0;
  logic [4:0]  rs_idx, rt_idx, rd_idx;
  logic [31:0] rs_val, rt_val, result, mem_addr;
  logic        wr_en, is_load, is_store, is_ctrl, illegal;
  logic [31:0] regs [32];

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] instr;
    logic        we;
    logic [4:0]  rd;
    logic [31:0] res;
    logic        ld, st, cf, ill;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  int_exec_unit i_int_exec_unit (
    .instr_i(instr), .rs_idx_o(rs_idx), .rt_idx_o(rt_idx),
    .rs_val_i(rs_val), .rt_val_i(rt_val), .rd_idx_o(rd_idx),
    .wr_en_o(wr_en), .result_o(result), .mem_addr_o(mem_addr),
    .is_load_o(is_load), .is_store_o(is_store), .is_ctrl_o(is_ctrl),
    .illegal_o(illegal)
  );

  assign rs_val = (rs_idx == 5'd0) ? 32'd0 : regs[rs_idx];
  assign rt_val = (rt_idx == 5'd0) ? 32'd0 : regs[rt_idx];

  function automatic logic [31:0] rfmt(input int rs, rt, rd, sh, fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] ifmt(input int op, rs, rt, input logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  task automatic apply(input logic [31:0] ins, input logic we, input int rd,
                       input logic [31:0] res, input logic ld, st, cf, ill,
                       input string tag);
    exp_t e;
    e.instr = ins; e.we = we; e.rd = 5'(rd); e.res = res;
    e.ld = ld; e.st = st; e.cf = cf; e.ill = ill; e.tag = tag;
    @(posedge clk);
    instr = ins;
    q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [31:0] exp_addr;
      bit ok;
      e = q.pop_front();
      n_vec++;
      exp_addr = (e.ld || e.st) ? e.res : 32'd0;
      ok = (wr_en === e.we) && (is_load === e.ld) && (is_store === e.st) &&
           (is_ctrl === e.cf) && (illegal === e.ill) && (mem_addr === exp_addr) &&
           (rs_idx === e.instr[25:21]) && (rt_idx === e.instr[20:16]);  // R9
      if (e.we || e.ld) ok = ok && (rd_idx === e.rd);
      if (e.we || e.ld || e.st) ok = ok && (result === e.res);
      if (!ok) begin
        n_bad++;
        $display("FAIL %s: got we=%b rd=%0d res=%h addr=%h ld=%b st=%b cf=%b ill=%b rs=%0d rt=%0d; exp we=%b rd=%0d res=%h addr=%h ld=%b st=%b cf=%b ill=%b rs=%0d rt=%0d",
                 e.tag, wr_en, rd_idx, result, mem_addr, is_load, is_store, is_ctrl, illegal,
                 rs_idx, rt_idx, e.we, e.rd, e.res, exp_addr, e.ld, e.st, e.cf, e.ill,
                 e.instr[25:21], e.instr[20:16]);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 32'd0;
    regs[1] = 32'd5;
    regs[2] = 32'd7;
    regs[3] = 32'hFFFF_FFFD;
    regs[4] = 32'h8000_0000;
    regs[5] = 32'h1234_5678;
    regs[6] = 32'h0000_00F0;
    regs[31] = 32'h0000_4000;

    // all-zero word: R-format funct 0, unsupported
    apply(32'd0, 0, 0, 0, 0, 0, 0, 1, "R11 zero word");
    // R1
    apply(rfmt(1, 2, 7, 0, 32), 1, 7, 32'd12, 0, 0, 0, 0, "R1 add");
    apply(rfmt(1, 2, 8, 0, 34), 1, 8, 32'hFFFF_FFFE, 0, 0, 0, 0, "R1 sub");
    apply(rfmt(2, 1, 8, 0, 34), 1, 8, 32'd2, 0, 0, 0, 0, "R1 sub order");
    apply(rfmt(4, 4, 9, 0, 32), 1, 9, 32'd0, 0, 0, 0, 0, "R1 add wrap");
    apply(rfmt(5, 6, 9, 0, 36), 1, 9, 32'h0000_0070, 0, 0, 0, 0, "R1 and");
    apply(rfmt(5, 6, 10, 0, 37), 1, 10, 32'h1234_56F8, 0, 0, 0, 0, "R1 or");
    // R2
    apply(rfmt(3, 1, 11, 0, 42), 1, 11, 32'd1, 0, 0, 0, 0, "R2 slt neg<pos");
    apply(rfmt(1, 3, 11, 0, 42), 1, 11, 32'd0, 0, 0, 0, 0, "R2 slt pos<neg");
    apply(rfmt(4, 1, 11, 0, 42), 1, 11, 32'd1, 0, 0, 0, 0, "R2 slt min");
    apply(rfmt(1, 1, 11, 0, 42), 1, 11, 32'd0, 0, 0, 0, 0, "R2 slt equal");
    apply(ifmt(10, 1, 12, 16'd6), 1, 12, 32'd1, 0, 0, 0, 0, "R2 slti 5<6");
    apply(ifmt(10, 1, 12, 16'hFFFF), 1, 12, 32'd0, 0, 0, 0, 0, "R2 slti 5<-1");
    apply(ifmt(10, 3, 12, 16'hFFFF), 1, 12, 32'd1, 0, 0, 0, 0, "R2 slti -3<-1");
    // R3
    apply(ifmt(8, 1, 13, 16'hFFFF), 1, 13, 32'd4, 0, 0, 0, 0, "R3 addi -1");
    apply(ifmt(8, 2, 13, 16'h0010), 1, 13, 32'd23, 0, 0, 0, 0, "R3 addi +16");
    // R4
    apply(ifmt(12, 5, 14, 16'hFFFF), 1, 14, 32'h0000_5678, 0, 0, 0, 0, "R4 andi");
    apply(ifmt(13, 4, 15, 16'h8001), 1, 15, 32'h8000_8001, 0, 0, 0, 0, "R4 ori");
    // R5
    apply(ifmt(15, 5, 16, 16'hABCD), 1, 16, 32'hABCD_0000, 0, 0, 0, 0, "R5 lui");
    apply(ifmt(15, 0, 16, 16'h8000), 1, 16, 32'h8000_0000, 0, 0, 0, 0, "R5 lui top");
    // R6
    apply(ifmt(35, 2, 17, 16'hFFFC), 1, 17, 32'd3, 1, 0, 0, 0, "R6 load -4");
    apply(ifmt(35, 31, 17, 16'h0008), 1, 17, 32'h0000_4008, 1, 0, 0, 0, "R6 load +8");
    // R7
    apply(ifmt(43, 5, 2, 16'h0004), 0, 2, 32'h1234_567C, 0, 1, 0, 0, "R7 store");
    apply(ifmt(43, 31, 0, 16'h8000), 0, 0, 32'hFFFF_C000, 0, 1, 0, 0, "R7 store neg");
    // R8
    apply(rfmt(1, 2, 0, 0, 32), 0, 0, 32'd12, 0, 0, 0, 0, "R8 add to r0");
    apply(ifmt(8, 1, 0, 16'd3), 0, 0, 32'd8, 0, 0, 0, 0, "R8 addi to r0");
    apply(ifmt(35, 1, 0, 16'd0), 0, 0, 32'd5, 1, 0, 0, 0, "R8 load to r0");
    // R10
    apply(rfmt(31, 0, 0, 0, 8), 0, 0, 0, 0, 0, 1, 0, "R10 jr");
    apply(ifmt(4, 1, 2, 16'd3), 0, 0, 0, 0, 0, 1, 0, "R10 beq");
    apply(ifmt(5, 1, 2, 16'd3), 0, 0, 0, 0, 0, 1, 0, "R10 bne");
    apply({6'd2, 26'h0000100}, 0, 0, 0, 0, 0, 1, 0, "R10 j");
    apply({6'd3, 26'h0000100}, 0, 0, 0, 0, 0, 1, 0, "R10 jal");
    // R11
    apply(rfmt(1, 2, 7, 1, 32), 0, 0, 0, 0, 0, 0, 1, "R11 shamt nonzero");
    apply(rfmt(1, 2, 7, 0, 33), 0, 0, 0, 0, 0, 0, 1, "R11 funct 33");
    apply(rfmt(31, 0, 0, 2, 8), 0, 0, 0, 0, 0, 0, 1, "R11 jr shamt");
    apply(ifmt(9, 1, 7, 16'd1), 0, 0, 0, 0, 0, 0, 1, "R11 op 9");
    apply(ifmt(63, 1, 7, 16'd1), 0, 0, 0, 0, 0, 0, 1, "R11 op 63");
    apply(ifmt(32, 1, 7, 16'd1), 0, 0, 0, 0, 0, 0, 1, "R11 op 32");

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule